// File: doc/BRIEF.md
# Pulse Position Histogram Searcher

This block finds the time slot inside a symbol period in which an on-off-keyed pulse stream arrives while a packet preamble is on the air. The system clock runs at ten times the symbol rate, so every symbol period is ten one-clock slots. A start-of-packet strobe sets the slot counter to zero. The block then samples the asynchronous pulse input twice per slot, once on the falling clock edge in the middle of the slot and once on the rising edge that ends it. Each slot keeps one hit counter for each of the two sampling edges.

Detection uses two pairs of detector flip-flops, one pair per edge. Each detector works through three steps: acquire, sample, clear. A full pass takes two slots, so the two detectors of a pair take turns slot by slot. After the sixteen preamble symbols the block waits one settle symbol, then compares all twenty counters. If the strongest count reaches the threshold, it reports the slot and the sampling edge, raises a tracking strobe, and from then on enables detection only in that slot. If no count reaches the threshold, it clears the histogram and starts a new search round straight away.

Top module: `pps_searcher`

## Requirements
- R1: While `rst` is high and after it falls, `found`, `track_en`, `edge_sel` and `slot_idx` are all 0 until a search completes.
- R2: Slot k is clock cycle k of each symbol, counted from the clock edge that samples `sop`. A pulse level present at the falling edge inside slot k adds one falling hit to slot k. A level present at the rising edge that ends slot k adds one rising hit to slot k.
- R3: A search round is 17 symbols (170 cycles). Only the first 16 symbols add hits; pulses in the 17th symbol are ignored. The decision is registered on the last clock edge of the round.
- R4: A round is accepted only if its largest per-slot count is at least 12. A best count of 11 gives no `found`.
- R5: For the winning slot, `edge_sel` is 1 (rising) when the rising count is strictly greater than the falling count. Otherwise it is 0 (falling), so ties go to the falling edge.
- R6: When two slots have the same best count, the slot with the lower index wins.
- R7: Hit counters stop at 15. Sixteen hits leave a count of 15.
- R8: When a round is rejected, all counters are cleared and the next round begins on the following cycle, with no hits carried over.
- R9: `track_en` is high for exactly one cycle, in the cycle after the accepting edge.
- R10: `found`, `slot_idx` and `edge_sel` hold their values until the next `sop`. The edge that samples `sop` clears all three.
- R11: Once a slot is accepted, the detectors are enabled only in that slot, and pulses in any slot leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, ten cycles per symbol |
| rst | input | 1 | Synchronous active-high reset |
| sop | input | 1 | Start-of-packet strobe; restarts the search |
| pulse_in | input | 1 | Asynchronous rail-to-rail pulse level |
| found | output | 1 | A slot has been accepted |
| slot_idx | output | 4 | Index of the accepted slot |
| edge_sel | output | 1 | Accepted edge: 0 falling, 1 rising |
| track_en | output | 1 | One-cycle strobe when a slot is accepted |

## Verification
The bench sweeps a clean pulse across all ten slots with noise in another slot. A design that counted a slot one cycle off would report a neighbouring index. It checks counts of 11 and 12 at the threshold, and it gives one edge a one-count lead on each side. It also sets up equal counts in two slots, and a 15-versus-16 case that exposes a counter that wraps to zero or grows past 15. It puts strong pulses into the settle symbol, which a design counting that symbol would pick up as a wrong winner. It runs a failed round followed by a good one in a different slot, which catches a histogram that keeps old hits. Finally it sends pulses into every slot after lock to show that the outputs stay fixed.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int DEF_SLOTS    = 10;
    localparam int DEF_CNT_W    = 4;
    localparam int DEF_PRE_SYMS = 16;
    localparam int DEF_THRESH   = 12;

    typedef enum logic [1:0] {
        SRCH_IDLE = 2'd0,
        SRCH_RUN  = 2'd1,
        SRCH_LOCK = 2'd2
    } srch_state_e;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_e;

    // larger of two counts; a tie keeps the first (falling) operand
    function automatic logic rise_wins(input logic [7:0] f_cnt, input logic [7:0] r_cnt);
        return r_cnt > f_cnt;
    endfunction

endpackage

// File: rtl/pps_slot_timer.sv
module pps_slot_timer #(
    parameter int NUM_SLOTS = 10,
    parameter int PRE_SYMS  = 16,
    parameter int SLOT_W    = 4,
    parameter int SYM_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    output logic [SLOT_W-1:0] slot,
    output logic [SYM_W-1:0]  sym,
    output logic              phase,
    output logic              round_end
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [SYM_W-1:0]  SETTLE    = SYM_W'(PRE_SYMS);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            slot  <= '0;
            sym   <= '0;
            phase <= 1'b0;
        end else begin
            phase <= ~phase;
            if (slot == LAST_SLOT) begin
                slot <= '0;
                sym  <= (sym == SETTLE) ? '0 : sym + 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    assign round_end = (slot == LAST_SLOT) && (sym == SETTLE);

    // R2
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        (slot <= LAST_SLOT) && (sym <= SETTLE));

endmodule

// File: rtl/pps_edge_det.sv
module pps_edge_det #(
    parameter bit RISING    = 1'b0,
    parameter int NUM_SLOTS = 10,
    parameter int SLOT_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 pulse_in,
    input  logic                 phase,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [NUM_SLOTS-1:0] acq_en,
    output logic                 hit,
    output logic [SLOT_W-1:0]    hit_slot
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    // one detector per slot parity; the pair alternates slot by slot
    logic [1:0] det;
    logic       sample;

    assign sample = pulse_in & acq_en[slot];

    generate
        if (RISING) begin : g_rise
            // acquire at the edge ending slot k, sample during slot k+1,
            // clear at the edge ending slot k+1
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    det <= '0;
                end else begin
                    for (int i = 0; i < 2; i++)
                        det[i] <= (1'(i) == phase) ? sample : 1'b0;
                end
            end
            assign hit      = det[~phase];
            assign hit_slot = (slot == '0) ? LAST_SLOT : slot - 1'b1;

            // R2
            det_reset_chk: assert property (@(posedge clk) disable iff (rst)
                !clr |=> (det[phase] == 1'b0));
        end else begin : g_fall
            // acquire mid slot k, sample at the edge ending slot k,
            // clear mid slot k+1
            always_ff @(negedge clk) begin
                if (rst) begin
                    det <= '0;
                end else begin
                    for (int i = 0; i < 2; i++)
                        det[i] <= (1'(i) == phase) ? sample : 1'b0;
                end
            end
            assign hit      = det[phase];
            assign hit_slot = slot;
        end
    endgenerate

endmodule

// File: rtl/pps_hist_bank.sv
module pps_hist_bank #(
    parameter int NUM_SLOTS = 10,
    parameter int CNT_W     = 4,
    parameter int SLOT_W    = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              clr,
    input  logic                              count_en,
    input  logic                              hit,
    input  logic [SLOT_W-1:0]                 hit_slot,
    output logic [NUM_SLOTS-1:0][CNT_W-1:0]   cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [NUM_SLOTS];

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bin
            logic bump;
            assign bump = count_en && hit && (hit_slot == SLOT_W'(g));

            always_ff @(posedge clk) begin
                if (rst || clr)
                    cnt_q[g] <= '0;
                else if (bump && (cnt_q[g] != CNT_MAX))
                    cnt_q[g] <= cnt_q[g] + 1'b1;
            end

            assign cnt[g] = cnt_q[g];

            // R7
            no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
                (!clr && bump && (cnt_q[g] == CNT_MAX)) |=> (cnt_q[g] == CNT_MAX));
        end
    endgenerate

endmodule

// File: rtl/pps_slot_picker.sv
module pps_slot_picker #(
    parameter int NUM_SLOTS = 10,
    parameter int CNT_W     = 4,
    parameter int SLOT_W    = 4
) (
    input  logic [NUM_SLOTS-1:0][CNT_W-1:0] cnt_f,
    input  logic [NUM_SLOTS-1:0][CNT_W-1:0] cnt_r,
    output logic [SLOT_W-1:0]               best_slot,
    output logic                            best_rise,
    output logic [CNT_W-1:0]                best_cnt
);
    always_comb begin
        best_slot = '0;
        best_rise = 1'b0;
        best_cnt  = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            logic             r_lead;
            logic [CNT_W-1:0] cand;
            r_lead = pps_pkg::rise_wins(8'(cnt_f[i]), 8'(cnt_r[i]));
            cand   = r_lead ? cnt_r[i] : cnt_f[i];
            // strict compare: the lowest index keeps a tie
            if (cand > best_cnt) begin
                best_cnt  = cand;
                best_slot = SLOT_W'(i);
                best_rise = r_lead;
            end
        end
    end

endmodule

// File: rtl/pps_searcher.sv
module pps_searcher
    import pps_pkg::*;
#(
    parameter  int NUM_SLOTS  = DEF_SLOTS,
    parameter  int PRE_SYMS   = DEF_PRE_SYMS,
    parameter  int CNT_W      = DEF_CNT_W,
    parameter  int HIT_THRESH = DEF_THRESH,
    localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sop,
    input  logic              pulse_in,
    output logic              found,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              edge_sel,
    output logic              track_en
);
    localparam int SYM_W = $clog2(PRE_SYMS + 1);

    srch_state_e state;
    edge_e       edge_q;

    logic [SLOT_W-1:0] slot;
    logic [SYM_W-1:0]  sym;
    logic              phase;
    logic              round_end;

    logic [NUM_SLOTS-1:0] acq_en;
    logic                 hit_f, hit_r;
    logic [SLOT_W-1:0]    hit_slot_f, hit_slot_r;

    logic [NUM_SLOTS-1:0][CNT_W-1:0] cnt_f, cnt_r;
    logic [SLOT_W-1:0]               best_slot;
    logic                            best_rise;
    logic [CNT_W-1:0]                best_cnt;

    logic accept, hist_clr, count_en, in_preamble;

    pps_slot_timer #(
        .NUM_SLOTS(NUM_SLOTS), .PRE_SYMS(PRE_SYMS), .SLOT_W(SLOT_W), .SYM_W(SYM_W)
    ) u_timer (
        .clk(clk), .rst(rst), .restart(sop),
        .slot(slot), .sym(sym), .phase(phase), .round_end(round_end)
    );

    // detector enables: every slot while the preamble runs, one slot after lock
    assign in_preamble = (state == SRCH_RUN) && (sym < SYM_W'(PRE_SYMS));

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_en
            assign acq_en[g] = in_preamble ||
                               ((state == SRCH_LOCK) && (slot_idx == SLOT_W'(g)));
        end
    endgenerate

    pps_edge_det #(.RISING(1'b0), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_det_fall (
        .clk(clk), .rst(rst), .clr(sop), .pulse_in(pulse_in), .phase(phase),
        .slot(slot), .acq_en(acq_en), .hit(hit_f), .hit_slot(hit_slot_f)
    );

    pps_edge_det #(.RISING(1'b1), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_det_rise (
        .clk(clk), .rst(rst), .clr(sop), .pulse_in(pulse_in), .phase(phase),
        .slot(slot), .acq_en(acq_en), .hit(hit_r), .hit_slot(hit_slot_r)
    );

    assign accept   = (best_cnt >= CNT_W'(HIT_THRESH));
    assign count_en = (state == SRCH_RUN);
    assign hist_clr = sop || ((state == SRCH_RUN) && round_end && !accept);

    pps_hist_bank #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_hist_fall (
        .clk(clk), .rst(rst), .clr(hist_clr), .count_en(count_en),
        .hit(hit_f), .hit_slot(hit_slot_f), .cnt(cnt_f)
    );

    pps_hist_bank #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_hist_rise (
        .clk(clk), .rst(rst), .clr(hist_clr), .count_en(count_en),
        .hit(hit_r), .hit_slot(hit_slot_r), .cnt(cnt_r)
    );

    pps_slot_picker #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_pick (
        .cnt_f(cnt_f), .cnt_r(cnt_r),
        .best_slot(best_slot), .best_rise(best_rise), .best_cnt(best_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SRCH_IDLE;
            found    <= 1'b0;
            slot_idx <= '0;
            edge_q   <= EDGE_FALL;
            track_en <= 1'b0;
        end else if (sop) begin
            state    <= SRCH_RUN;
            found    <= 1'b0;
            slot_idx <= '0;
            edge_q   <= EDGE_FALL;
            track_en <= 1'b0;
        end else begin
            track_en <= 1'b0;
            if ((state == SRCH_RUN) && round_end && accept) begin
                state    <= SRCH_LOCK;
                found    <= 1'b1;
                slot_idx <= best_slot;
                edge_q   <= best_rise ? EDGE_RISE : EDGE_FALL;
                track_en <= 1'b1;
            end
        end
    end

    assign edge_sel = edge_q;

    // R9
    track_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        track_en |=> !track_en);

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (found && !sop) |=> (found && $stable(slot_idx) && $stable(edge_sel)));

    // R4
    accept_min_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(found) |-> ($past(best_cnt) >= CNT_W'(HIT_THRESH)));

    // R3
    decide_time_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(found) |-> $past(round_end));

    // R11
    locked_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SRCH_LOCK) |-> ($onehot0(acq_en) && ((acq_en == '0) || acq_en[slot_idx])));

endmodule

// File: tb/pps_searcher_test.sv
module pps_searcher_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sop = 1'b0;
    logic       pulse_in = 1'b0;
    logic       found;
    logic [3:0] slot_idx;
    logic       edge_sel;
    logic       track_en;

    int n_chk  = 0;
    int n_fail = 0;

    // per round, per slot: number of leading preamble symbols carrying a pulse
    int hf [3][10];
    int hr [3][10];
    bit sf [10];
    bit sr [10];

    always #5 clk = ~clk;

    pps_searcher uut (
        .clk(clk), .rst(rst), .sop(sop), .pulse_in(pulse_in),
        .found(found), .slot_idx(slot_idx), .edge_sel(edge_sel), .track_en(track_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_cfg();
        for (int r = 0; r < 3; r++)
            for (int k = 0; k < 10; k++) begin
                hf[r][k] = 0;
                hr[r][k] = 0;
            end
        for (int k = 0; k < 10; k++) begin
            sf[k] = 1'b0;
            sr[k] = 1'b0;
        end
    endtask

    // called at 2 ns after a rising edge; returns at the same offset
    task automatic run_search(input string tag, input int nrounds);
        sop = 1'b1;
        #10;
        sop = 1'b0;
        check({tag, " R10 sop clears found"}, found, 0);
        check({tag, " R10 sop clears slot"}, slot_idx, 0);
        for (int r = 0; r < nrounds; r++) begin
            int best, bslot, brise;
            for (int j = 0; j < 170; j++) begin
                int s, k;
                s = j / 10;
                k = j % 10;
                pulse_in = (s < 16) ? (s < hf[r][k]) : sf[k];
                #5;
                pulse_in = (s < 16) ? (s < hr[r][k]) : sr[k];
                #5;
            end
            pulse_in = 1'b0;
            best = 0; bslot = 0; brise = 0;
            for (int k = 0; k < 10; k++) begin
                int cf, cr, cand;
                cf = (hf[r][k] > 15) ? 15 : hf[r][k];
                cr = (hr[r][k] > 15) ? 15 : hr[r][k];
                cand = (cr > cf) ? cr : cf;
                if (cand > best) begin
                    best = cand;
                    bslot = k;
                    brise = (cr > cf) ? 1 : 0;
                end
            end
            if (best >= 12) begin
                check({tag, " R3 found at round end"}, found, 1);
                check({tag, " R2 R6 slot"}, slot_idx, bslot);
                check({tag, " R5 edge"}, edge_sel, brise);
                check({tag, " R9 strobe high"}, track_en, 1);
                #10;
                check({tag, " R9 strobe one cycle"}, track_en, 0);
                return;
            end else begin
                check({tag, " R4 R8 rejected round"}, found, 0);
                check({tag, " R8 no strobe"}, track_en, 0);
            end
        end
    endtask

    initial begin
        #1_500_000;
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_cfg();
        @(posedge clk);
        #2;
        #30;
        // R1 reset state
        check("R1 found in reset", found, 0);
        check("R1 strobe in reset", track_en, 0);
        rst = 1'b0;
        #30;
        check("R1 found after reset", found, 0);
        check("R1 slot after reset", slot_idx, 0);
        check("R1 edge after reset", edge_sel, 0);
        check("R1 strobe after reset", track_en, 0);

        // R2 R5 R7 sweep of a strong slot with noise elsewhere
        for (int k = 0; k < 10; k++) begin
            clear_cfg();
            hf[0][k] = 16;
            hr[0][k] = 16;
            hf[0][(k + 3) % 10] = 4;
            hr[0][(k + 7) % 10] = 2;
            run_search("sweep", 1);
        end

        // R5 rising edge only
        clear_cfg();
        hr[0][6] = 14;
        run_search("rise only", 1);

        // R5 one-count lead either way
        clear_cfg();
        hf[0][2] = 13; hr[0][2] = 14;
        run_search("rise lead", 1);
        clear_cfg();
        hf[0][2] = 14; hr[0][2] = 13;
        run_search("fall lead", 1);

        // R4 exactly at threshold
        clear_cfg();
        hf[0][9] = 12;
        run_search("at thresh", 1);

        // R8 rejected round then a different winner, no carried hits
        clear_cfg();
        hf[0][4] = 11; hr[0][4] = 11;
        hf[1][4] = 11; hr[1][4] = 11;
        hf[1][7] = 12; hr[1][7] = 12;
        run_search("restart", 2);

        // R6 equal counts in two slots
        clear_cfg();
        hf[0][8] = 16;
        hr[0][2] = 16;
        run_search("slot tie", 1);

        // R7 sixteen hits equal fifteen hits, lower slot wins
        clear_cfg();
        hf[0][1] = 15;
        hf[0][5] = 16; hr[0][5] = 16;
        run_search("saturate", 1);

        // R3 settle symbol ignored
        clear_cfg();
        hf[0][0] = 11; hr[0][0] = 11;
        sf[0] = 1'b1; sr[0] = 1'b1;
        hf[0][2] = 12;
        run_search("settle", 1);

        // R10 R11 pulses everywhere after lock leave outputs fixed
        pulse_in = 1'b1;
        #3000;
        pulse_in = 1'b0;
        check("R10 R11 found held", found, 1);
        check("R10 R11 slot held", slot_idx, 2);
        check("R10 R11 edge held", edge_sel, 0);
        check("R11 no new strobe", track_en, 0);

        // R8 two rejected rounds before acceptance
        clear_cfg();
        hf[0][3] = 11;
        hr[1][6] = 11;
        hf[2][3] = 16;
        run_search("three rounds", 3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule